// File: doc/BRIEF.md
# Multithreaded Stream Issue Scheduler

This block picks one hardware instruction stream per clock cycle out of a pool of stream contexts, so that a pipeline can change streams every cycle at no cost. A stream that waits on memory is marked stalled and skipped. A stream that has used up its allowance of outstanding memory references is also skipped until one of them completes. Any other active stream takes its issue slot, so memory latency is covered by work from the other streams.

The stream chosen in a cycle is reported on the issue port. In the same cycle, the pipeline tells the block whether that stream's operation is a memory reference and gives its address and direction. The block then drives the memory request port, which accepts or rejects the request within that cycle. A rejected reference goes into a retry pool and is offered again on later cycles with no action from the stream. Completions come back tagged with a stream number and free one slot of that stream's allowance.

Top module: `stream_issue_sched`

## Requirements
- R1: Stream contexts are numbered 0 to NUM_STREAMS-1 (default 128). A stream is made active or inactive through the control port, and only active streams are issued.
- R2: Ready streams are chosen in rotating order. The search starts at the stream number just above the last issued stream and wraps from the highest number to the lowest. After reset the search starts at stream 0.
- R3: A stream marked stalled is never chosen, and other ready streams are issued in its place. Once the stall is cleared, the stream returns to the rotation.
- R4: Each stream reserves one slot when it issues a memory operation and releases one slot when a completion tagged with its number arrives. A stream holding MAX_OUTSTANDING (default 8) slots is not issued until a completion arrives.
- R5: A reservation and a release for the same stream in the same cycle leave its slot count unchanged.
- R6: A reference that is rejected goes into the retry pool and is later presented again with the same stream number, address and direction. Entries leave the pool in arrival order, and the pool head stays at the front until it is accepted.
- R7: While the retry pool holds anything, the memory port presents the pool head. A new memory operation issued in that cycle is queued behind the entries already in the pool.
- R8: While the retry pool is full (POOL_DEPTH entries, default 16), nothing is issued when the offered operation is a memory reference. Non-memory operations keep issuing.
- R9: When no stream is ready, issue_valid is low. When, in addition, the pool is empty, mem_req_valid is low too.
- R10: A synchronous reset with rst_n low makes every stream inactive and unstalled, clears every slot count and empties the retry pool.
- R11: When the pool is empty and a memory operation issues, the memory request carries the issued stream number and the offered address and direction in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl_act_valid | input | 1 | Applies an activity change to one stream |
| ctl_act_id | input | SID_W | Stream whose activity changes |
| ctl_act_on | input | 1 | 1 makes the stream active, 0 makes it inactive |
| ctl_stall_valid | input | 1 | Applies a stall change to one stream |
| ctl_stall_id | input | SID_W | Stream whose stall mark changes |
| ctl_stall_on | input | 1 | 1 marks the stream stalled, 0 clears the mark |
| op_is_mem | input | 1 | The issued stream's operation is a memory reference |
| op_addr | input | ADDR_W | Address of that memory reference |
| op_write | input | 1 | 1 for a write, 0 for a read |
| issue_valid | output | 1 | A stream is issued this cycle |
| issue_id | output | SID_W | Number of the issued stream |
| mem_req_valid | output | 1 | A memory request is presented |
| mem_req_id | output | SID_W | Stream that owns the presented request |
| mem_req_addr | output | ADDR_W | Address of the presented request |
| mem_req_write | output | 1 | Direction of the presented request |
| mem_accept | input | 1 | The memory side takes the presented request; low means reject |
| cpl_valid | input | 1 | A memory reference has completed |
| cpl_id | input | SID_W | Stream that owns the completed reference |

## Verification
The checker relies on three things about the inputs. Completions only arrive for streams that still hold reserved slots. Activity and stall changes are applied one stream per cycle through their ports. mem_accept is only looked at while a request is presented. The directed scenarios respect all three: every completion the bench sends matches a reference it issued before, control changes go one at a time through tasks that pulse the valid strobe for one cycle, and acceptance is held steady over each phase of a scenario. With these inputs, the checker's own record of reservations and stall marks stays in step with what the block has been told.

// File: rtl/sched_pkg.sv
// Package: shared types of the stream issue scheduler.
// Assumes: imported by the top module only.
package sched_pkg;

    // Source that drives the memory request port in a cycle.
    typedef enum logic [1:0] {
        PORT_IDLE       = 2'd0,
        PORT_FROM_POOL  = 2'd1,
        PORT_FROM_ISSUE = 2'd2
    } port_src_e;

endpackage

// File: rtl/stream_state.sv
// Module: stream_state
// Holds the per-stream context bits (active, stalled) and the count of
// reserved memory slots, and derives one ready bit per stream.
// Assumes: at most one activity change, one stall change, one reservation
// and one release per cycle; releases only target streams holding slots.
module stream_state #(
    parameter int N       = 128,
    parameter int MAX_OUT = 8,
    localparam int SID_W  = $clog2(N),
    localparam int CNT_W  = $clog2(MAX_OUT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_valid,
    input  logic [SID_W-1:0] act_id,
    input  logic             act_on,
    input  logic             stall_valid,
    input  logic [SID_W-1:0] stall_id,
    input  logic             stall_on,
    input  logic             rsv_valid,
    input  logic [SID_W-1:0] rsv_id,
    input  logic             rel_valid,
    input  logic [SID_W-1:0] rel_id,
    output logic [N-1:0]     ready
);

    for (genvar g = 0; g < N; g++) begin : g_stream
        logic             active;
        logic             stalled;
        logic [CNT_W-1:0] slots;
        logic             rsv_hit;
        logic             rel_hit;

        assign rsv_hit = rsv_valid && (rsv_id == SID_W'(g));
        assign rel_hit = rel_valid && (rel_id == SID_W'(g));

        // Activity bit: set or cleared by the control port.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                active <= 1'b0;
            end else if (act_valid && (act_id == SID_W'(g))) begin
                active <= act_on;
            end
        end

        // Stall mark: set while the stream waits on memory.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stalled <= 1'b0;
            end else if (stall_valid && (stall_id == SID_W'(g))) begin
                stalled <= stall_on;
            end
        end

        // Reserved slot count: up on reservation, down on release, both cancel.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slots <= '0;
            end else begin
                case ({rsv_hit, rel_hit})
                    2'b10:   slots <= slots + 1'b1;
                    2'b01:   if (slots != '0) slots <= slots - 1'b1;
                    default: slots <= slots;
                endcase
            end
        end

        // Ready when active, unstalled and below the slot cap.
        assign ready[g] = active && !stalled && (slots < CNT_W'(MAX_OUT));
    end

endmodule

// File: rtl/rr_picker.sv
// Module: rr_picker
// Rotating-priority selector: picks the lowest requesting index above the
// last grant, otherwise the lowest requesting index overall.
// Assumes: purely combinational; the caller registers the last grant.
module rr_picker #(
    parameter int N      = 128,
    localparam int SID_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    input  logic [SID_W-1:0] last,
    output logic             grant_valid,
    output logic [SID_W-1:0] grant_id
);

    logic             above_found;
    logic [SID_W-1:0] above_id;
    logic             any_found;
    logic [SID_W-1:0] any_id;

    // Scan downward so the last hit kept is the lowest index in each set.
    always_comb begin
        above_found = 1'b0;
        above_id    = '0;
        any_found   = 1'b0;
        any_id      = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any_found = 1'b1;
                any_id    = SID_W'(i);
                if (SID_W'(i) > last) begin
                    above_found = 1'b1;
                    above_id    = SID_W'(i);
                end
            end
        end
        grant_valid = any_found;
        grant_id    = above_found ? above_id : any_id;
    end

endmodule

// File: rtl/retry_pool.sv
// Module: retry_pool
// First-in first-out store for rejected memory references.
// Assumes: the caller never pushes while full; a pop on empty is ignored.
module retry_pool #(
    parameter int DEPTH  = 16,
    parameter int W      = 40,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);

    logic [W-1:0]     slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] fill;
    logic             do_push;
    logic             do_pop;

    assign empty   = (fill == '0);
    assign full    = (fill == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = slots[rd_ptr];

    // Entry storage: written at the tail.
    always_ff @(posedge clk) begin
        if (do_push) begin
            slots[wr_ptr] <= din;
        end
    end

    // Tail pointer with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
        end else if (do_push) begin
            wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
        end
    end

    // Head pointer with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
        end else if (do_pop) begin
            rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
        end
    end

    // Occupancy: push and pop together leave it unchanged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill <= '0;
        end else begin
            case ({do_push, do_pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

endmodule

// File: rtl/stream_issue_sched.sv
// Module: stream_issue_sched (top)
// Chooses one ready stream per cycle in rotating order, reserves a memory
// slot for it when its operation is a memory reference, presents references
// to memory with the retry pool first, and parks rejected references.
// Assumes: op_* describe the operation of the stream shown on issue_id in
// the same cycle; mem_accept answers the presented request combinationally.
module stream_issue_sched
    import sched_pkg::*;
#(
    parameter int NUM_STREAMS     = 128,
    parameter int MAX_OUTSTANDING = 8,
    parameter int POOL_DEPTH      = 16,
    parameter int ADDR_W          = 32,
    localparam int SID_W          = $clog2(NUM_STREAMS),
    localparam int ENTRY_W        = SID_W + ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_act_valid,
    input  logic [SID_W-1:0]  ctl_act_id,
    input  logic              ctl_act_on,
    input  logic              ctl_stall_valid,
    input  logic [SID_W-1:0]  ctl_stall_id,
    input  logic              ctl_stall_on,
    input  logic              op_is_mem,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic              op_write,
    output logic              issue_valid,
    output logic [SID_W-1:0]  issue_id,
    output logic              mem_req_valid,
    output logic [SID_W-1:0]  mem_req_id,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic              mem_req_write,
    input  logic              mem_accept,
    input  logic              cpl_valid,
    input  logic [SID_W-1:0]  cpl_id
);

    logic [NUM_STREAMS-1:0] ready_vec;
    logic                   pick_valid;
    logic [SID_W-1:0]       pick_id;
    logic [SID_W-1:0]       last_id;
    logic                   new_mem;
    logic                   pool_push;
    logic                   pool_pop;
    logic                   pool_empty;
    logic                   pool_full;
    logic [ENTRY_W-1:0]     pool_din;
    logic [ENTRY_W-1:0]     pool_dout;
    logic [SID_W-1:0]       head_id;
    logic [ADDR_W-1:0]      head_addr;
    logic                   head_write;
    port_src_e              port_src;

    stream_state #(
        .N       (NUM_STREAMS),
        .MAX_OUT (MAX_OUTSTANDING)
    ) u_state (
        .clk         (clk),
        .rst_n       (rst_n),
        .act_valid   (ctl_act_valid),
        .act_id      (ctl_act_id),
        .act_on      (ctl_act_on),
        .stall_valid (ctl_stall_valid),
        .stall_id    (ctl_stall_id),
        .stall_on    (ctl_stall_on),
        .rsv_valid   (new_mem),
        .rsv_id      (issue_id),
        .rel_valid   (cpl_valid),
        .rel_id      (cpl_id),
        .ready       (ready_vec)
    );

    rr_picker #(
        .N (NUM_STREAMS)
    ) u_pick (
        .req         (ready_vec),
        .last        (last_id),
        .grant_valid (pick_valid),
        .grant_id    (pick_id)
    );

    retry_pool #(
        .DEPTH (POOL_DEPTH),
        .W     (ENTRY_W)
    ) u_pool (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (pool_push),
        .din   (pool_din),
        .pop   (pool_pop),
        .dout  (pool_dout),
        .empty (pool_empty),
        .full  (pool_full)
    );

    // Issue gate: a memory operation cannot issue while the pool is full.
    always_comb begin
        issue_valid = pick_valid && !(op_is_mem && pool_full);
        issue_id    = pick_id;
        new_mem     = issue_valid && op_is_mem;
    end

    // Rotation point: remember the stream issued last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_id <= SID_W'(NUM_STREAMS - 1);
        end else if (issue_valid) begin
            last_id <= issue_id;
        end
    end

    // Pool entry layout: stream, address, direction.
    assign pool_din = {issue_id, op_addr, op_write};
    assign {head_id, head_addr, head_write} = pool_dout;

    // Port source: the pool head wins over a fresh reference.
    always_comb begin
        port_src = PORT_IDLE;
        if (!pool_empty) begin
            port_src = PORT_FROM_POOL;
        end else if (new_mem) begin
            port_src = PORT_FROM_ISSUE;
        end
    end

    // Memory request fields from the selected source.
    always_comb begin
        mem_req_valid = 1'b0;
        mem_req_id    = issue_id;
        mem_req_addr  = op_addr;
        mem_req_write = op_write;
        case (port_src)
            PORT_FROM_POOL: begin
                mem_req_valid = 1'b1;
                mem_req_id    = head_id;
                mem_req_addr  = head_addr;
                mem_req_write = head_write;
            end
            PORT_FROM_ISSUE: begin
                mem_req_valid = 1'b1;
            end
            default: begin
                mem_req_valid = 1'b0;
            end
        endcase
    end

    // Pool traffic: pop an accepted head, park a fresh reference that was
    // rejected or that had to wait behind the pool.
    always_comb begin
        pool_pop  = (port_src == PORT_FROM_POOL) && mem_accept;
        pool_push = new_mem && ((port_src == PORT_FROM_POOL) || !mem_accept);
    end

endmodule

// File: rtl/sched_checker.sv
// Module: sched_checker
// Property checks for stream_issue_sched, attached with bind below. Keeps
// its own record of reserved slots and stall marks from the port traffic.
// Assumes: completions only target streams holding reserved slots.
module sched_checker #(
    parameter int N       = 128,
    parameter int MAX_OUT = 8,
    parameter int SID_W   = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N-1:0]     ready,
    input logic             issue_valid,
    input logic [SID_W-1:0] issue_id,
    input logic             op_is_mem,
    input logic             stall_valid,
    input logic [SID_W-1:0] stall_id,
    input logic             stall_on,
    input logic             cpl_valid,
    input logic [SID_W-1:0] cpl_id,
    input logic             mem_req_valid,
    input logic             mem_accept,
    input logic             pool_full
);

    logic [7:0] seen_slots [N];
    logic       seen_stall [N];

    // Shadow record of reservations and stall marks taken from the ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                seen_slots[i] <= '0;
                seen_stall[i] <= 1'b0;
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                if (issue_valid && op_is_mem && (issue_id == SID_W'(i)) &&
                    !(cpl_valid && (cpl_id == SID_W'(i)))) begin
                    seen_slots[i] <= seen_slots[i] + 8'd1;
                end else if (cpl_valid && (cpl_id == SID_W'(i)) &&
                             !(issue_valid && op_is_mem && (issue_id == SID_W'(i))) &&
                             (seen_slots[i] != 8'd0)) begin
                    seen_slots[i] <= seen_slots[i] - 8'd1;
                end
                if (stall_valid && (stall_id == SID_W'(i))) begin
                    seen_stall[i] <= stall_on;
                end
            end
        end
    end

    // R2: the issued stream is one of the ready streams.
    a_r2_grant_is_ready: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> ready[issue_id]);

    // R3: a stream marked stalled is never issued.
    a_r3_no_stalled_issue: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> !seen_stall[issue_id]);

    // R4: a stream at the slot cap is never issued.
    a_r4_cap_respected: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> (seen_slots[issue_id] < 8'(MAX_OUT)));

    // R6: a rejected request is presented again on the next cycle.
    a_r6_reject_retried: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_accept) |=> mem_req_valid);

    // R8: a full pool whose head is rejected stays full.
    a_r8_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pool_full && !mem_accept) |=> pool_full);

    // R9: no ready stream means no issue.
    a_r9_idle_without_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (ready == '0) |-> !issue_valid);

endmodule

bind stream_issue_sched sched_checker #(
    .N       (NUM_STREAMS),
    .MAX_OUT (MAX_OUTSTANDING),
    .SID_W   (SID_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ready         (ready_vec),
    .issue_valid   (issue_valid),
    .issue_id      (issue_id),
    .op_is_mem     (op_is_mem),
    .stall_valid   (ctl_stall_valid),
    .stall_id      (ctl_stall_id),
    .stall_on      (ctl_stall_on),
    .cpl_valid     (cpl_valid),
    .cpl_id        (cpl_id),
    .mem_req_valid (mem_req_valid),
    .mem_accept    (mem_accept),
    .pool_full     (pool_full)
);

// File: tb/stream_issue_sched_test.sv
// Directed bench for stream_issue_sched: one task per scenario.
module stream_issue_sched_test;

    localparam int SID_W  = 7;
    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              ctl_act_valid;
    logic [SID_W-1:0]  ctl_act_id;
    logic              ctl_act_on;
    logic              ctl_stall_valid;
    logic [SID_W-1:0]  ctl_stall_id;
    logic              ctl_stall_on;
    logic              op_is_mem;
    logic [ADDR_W-1:0] op_addr;
    logic              op_write;
    logic              issue_valid;
    logic [SID_W-1:0]  issue_id;
    logic              mem_req_valid;
    logic [SID_W-1:0]  mem_req_id;
    logic [ADDR_W-1:0] mem_req_addr;
    logic              mem_req_write;
    logic              mem_accept;
    logic              cpl_valid;
    logic [SID_W-1:0]  cpl_id;

    int total = 0;
    int bad   = 0;

    stream_issue_sched uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .ctl_act_valid   (ctl_act_valid),
        .ctl_act_id      (ctl_act_id),
        .ctl_act_on      (ctl_act_on),
        .ctl_stall_valid (ctl_stall_valid),
        .ctl_stall_id    (ctl_stall_id),
        .ctl_stall_on    (ctl_stall_on),
        .op_is_mem       (op_is_mem),
        .op_addr         (op_addr),
        .op_write        (op_write),
        .issue_valid     (issue_valid),
        .issue_id        (issue_id),
        .mem_req_valid   (mem_req_valid),
        .mem_req_id      (mem_req_id),
        .mem_req_addr    (mem_req_addr),
        .mem_req_write   (mem_req_write),
        .mem_accept      (mem_accept),
        .cpl_valid       (cpl_valid),
        .cpl_id          (cpl_id)
    );

    always #4 clk = ~clk;

    initial begin
        #(8 * 100000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Advance to two time units after the next rising edge.
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        rst_n           = 1'b0;
        ctl_act_valid   = 1'b0;
        ctl_act_id      = '0;
        ctl_act_on      = 1'b0;
        ctl_stall_valid = 1'b0;
        ctl_stall_id    = '0;
        ctl_stall_on    = 1'b0;
        op_is_mem       = 1'b0;
        op_addr         = '0;
        op_write        = 1'b0;
        mem_accept      = 1'b0;
        cpl_valid       = 1'b0;
        cpl_id          = '0;
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
    endtask

    task automatic set_act(input int id, input logic on);
        ctl_act_valid = 1'b1;
        ctl_act_id    = SID_W'(id);
        ctl_act_on    = on;
        tick();
        ctl_act_valid = 1'b0;
    endtask

    task automatic test_reset();
        do_reset();
        op_is_mem = 1'b1;
        #1;
        chk("R10 issue_valid after reset", issue_valid, 0);
        chk("R10 mem_req_valid after reset", mem_req_valid, 0);
    endtask

    task automatic test_rotation();
        do_reset();
        set_act(3, 1'b1);
        set_act(5, 1'b1);
        set_act(127, 1'b1);
        #1;
        chk("R1 highest stream issues", issue_valid, 1);
        chk("R2 after 5 comes 127", issue_id, 127);
        tick(); #1;
        chk("R2 wrap to 3", issue_id, 3);
        tick(); #1;
        chk("R2 then 5", issue_id, 5);
        tick(); #1;
        chk("R2 then 127", issue_id, 127);
    endtask

    task automatic test_stall();
        do_reset();
        set_act(3, 1'b1);
        set_act(5, 1'b1);
        set_act(127, 1'b1);
        ctl_stall_valid = 1'b1; ctl_stall_id = 7'd5; ctl_stall_on = 1'b1;
        #1;
        chk("R3 stall not yet seen", issue_id, 127);
        tick(); ctl_stall_valid = 1'b0; #1;
        chk("R3 stream 3 next", issue_id, 3);
        tick(); #1;
        chk("R3 stalled 5 skipped", issue_id, 127);
        tick();
        ctl_stall_valid = 1'b1; ctl_stall_id = 7'd5; ctl_stall_on = 1'b0;
        #1;
        chk("R3 rotation continues", issue_id, 3);
        tick(); ctl_stall_valid = 1'b0; #1;
        chk("R3 cleared stream returns", issue_id, 5);
    endtask

    task automatic test_deactivate();
        do_reset();
        set_act(3, 1'b1);
        set_act(5, 1'b1);
        set_act(127, 1'b1);
        ctl_act_valid = 1'b1; ctl_act_id = 7'd127; ctl_act_on = 1'b0;
        #1;
        chk("R1 127 still active", issue_id, 127);
        tick(); ctl_act_valid = 1'b0; #1;
        chk("R1 then 3", issue_id, 3);
        tick(); #1;
        chk("R1 then 5", issue_id, 5);
        tick(); #1;
        chk("R1 inactive 127 skipped", issue_id, 3);
        set_act(3, 1'b0);
        set_act(5, 1'b0);
        op_is_mem = 1'b1;
        #1;
        chk("R9 no issue without ready", issue_valid, 0);
        chk("R9 no memory request", mem_req_valid, 0);
    endtask

    task automatic test_cap();
        do_reset();
        set_act(9, 1'b1);
        op_is_mem = 1'b1; op_addr = 32'h1000_0040; op_write = 1'b1; mem_accept = 1'b1;
        for (int k = 0; k < 8; k++) begin
            #1;
            if (k == 0) begin
                chk("R11 request stream", mem_req_id, 9);
                chk("R11 request addr", mem_req_addr, 32'h1000_0040);
                chk("R11 request write", mem_req_write, 1);
                chk("R11 request valid", mem_req_valid, 1);
                chk("R11 issue stream", issue_id, 9);
            end
            chk("R4 issue below cap", issue_valid, 1);
            tick();
        end
        cpl_valid = 1'b1; cpl_id = 7'd9;
        #1;
        chk("R4 blocked at cap", issue_valid, 0);
        chk("R9 idle memory port", mem_req_valid, 0);
        tick(); #1;
        chk("R4 released by completion", issue_valid, 1);
        tick(); cpl_valid = 1'b0; #1;
        chk("R5 reserve and release cancel", issue_valid, 1);
        tick(); #1;
        chk("R4 back at cap", issue_valid, 0);
    endtask

    task automatic test_retry();
        do_reset();
        set_act(9, 1'b1);
        op_is_mem = 1'b1; op_addr = 32'h0000_0100; op_write = 1'b0; mem_accept = 1'b0;
        #1;
        chk("R11 first addr presented", mem_req_addr, 32'h0000_0100);
        tick();
        op_addr = 32'h0000_0200;
        #1;
        chk("R7 pool head presented", mem_req_addr, 32'h0000_0100);
        chk("R7 new op still issues", issue_valid, 1);
        tick();
        op_is_mem = 1'b0; mem_accept = 1'b1;
        #1;
        chk("R6 retried addr unchanged", mem_req_addr, 32'h0000_0100);
        chk("R6 retried stream", mem_req_id, 9);
        chk("R6 retried direction", mem_req_write, 0);
        tick(); #1;
        chk("R6 second entry in order", mem_req_addr, 32'h0000_0200);
        tick(); #1;
        chk("R6 pool drained", mem_req_valid, 0);
    endtask

    task automatic test_pool_full();
        do_reset();
        set_act(1, 1'b1);
        set_act(2, 1'b1);
        set_act(3, 1'b1);
        op_is_mem = 1'b1; op_addr = 32'h0000_0800; mem_accept = 1'b0;
        for (int k = 0; k < 16; k++) begin
            #1;
            chk("R8 issue while filling", issue_valid, 1);
            tick();
        end
        #1;
        chk("R8 memory issue held when full", issue_valid, 0);
        op_is_mem = 1'b0;
        #1;
        chk("R8 non-memory issue continues", issue_valid, 1);
        chk("R8 head still presented", mem_req_valid, 1);
        op_is_mem = 1'b1; mem_accept = 1'b1;
        #1;
        chk("R8 still full before pop", issue_valid, 0);
        tick(); #1;
        chk("R8 issue resumes after pop", issue_valid, 1);
    endtask

    initial begin
        test_reset();
        test_rotation();
        test_stall();
        test_deactivate();
        test_cap();
        test_retry();
        test_pool_full();
        test_reset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule